// File: doc/BRIEF.md
# Double-Buffered Timer PWM Generator

This block drives one pulse-width-modulated output from an internal time base. A prescaler divides the input clock by 1, 8, 64 or 256, and each prescaled tick advances a counter that runs from zero up to a programmed period value and then wraps. The output is high while the counter is below the active duty value and low for the rest of the period.

Software writes a period value and a duty value through a one-cycle synchronous write port. Both values are held in staging registers. They move into the active registers only when the counter wraps at the end of a period, or at the moment the block is enabled. A write in the middle of a period therefore never shortens or splits a pulse. A duty of zero keeps the output low. A duty above the period value keeps the output high.

Top module: `pwm_dbuf`

## Requirements
- R1: With a period value of N and a divide ratio D, every PWM period lasts exactly (N+1)·D input clock cycles. For example, N=7 and D=1 give 8 cycles.
- R2: `psc_sel` selects the divide ratio as follows: 0 divides by 1, 1 by 8, 2 by 64 and 3 by 256.
- R3: For a duty value d with d ≤ N+1, the output is high for the first d·D cycles of each period and low for the remaining cycles. The output goes high on the first cycle of a period.
- R4: A duty write made in the middle of a period leaves that period unchanged. The new value governs the following period.
- R5: A period write made in the middle of a period leaves that period's length unchanged. The new length applies from the next period.
- R6: A duty value of 0 keeps the output low for the whole period. This includes the case where period and duty are both 0.
- R7: A duty value greater than the period value keeps the output high for the whole period.
- R8: While `en` is low, the counter is held at zero and the output is low from the next clock. Raising `en` starts a new period at once, using the staged period and duty values.
- R9: After reset the output is low and both staging registers are 0.
- R10: A write with `wr_sel`=0 stores the period value and a write with `wr_sel`=1 stores the duty value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable |
| psc_sel | input | 2 | Prescale select |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 period, 1 duty |
| wr_data | input | 16 | Write data |
| pwm_out | output | 1 | PWM output |

## Verification
The properties assume that `psc_sel` is changed only while `en` is low, because the tick spacing is undefined during a change of ratio. The bench reprograms the prescaler only inside the disabled gap between runs. Register writes arrive at any point of a running period, and the properties expect the active values to change only at a wrap or at enable. The bench keeps mid-period writes within a single period, so that the two measured periods bracket each write.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
   typedef enum logic [1:0] {
      PSC_DIV_A = 2'd0,
      PSC_DIV_B = 2'd1,
      PSC_DIV_C = 2'd2,
      PSC_DIV_D = 2'd3
   } psc_e;

   localparam logic SEL_PERIOD = 1'b0;
   localparam logic SEL_DUTY   = 1'b1;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             wr_sel,
   input  logic [CNT_W-1:0] wr_data,
   output logic [CNT_W-1:0] per_stg,
   output logic [CNT_W-1:0] duty_stg
);
   import pwm_pkg::*;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         per_stg  <= '0;
         duty_stg <= '0;
      end else if (wr_en) begin
         if (wr_sel == SEL_PERIOD) per_stg  <= wr_data;
         else                      duty_stg <= wr_data;
      end
   end
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
   parameter int DIV_B   = 8,
   parameter int DIV_C   = 64,
   parameter int DIV_D   = 256,
   parameter bit HAS_PSC = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic [1:0] sel,
   output logic       tick
);
   import pwm_pkg::*;

   localparam int PSC_CW = (DIV_D > 2) ? $clog2(DIV_D) : 1;

   if (DIV_B < 1 || DIV_C < DIV_B || DIV_D < DIV_C) begin : g_bad_div
      $error("pwm_prescaler: divide ratios must be ascending and at least 1");
   end

   if (HAS_PSC) begin : g_div
      logic [PSC_CW-1:0] cnt_q;
      logic [PSC_CW-1:0] lim;

      always_comb begin
         unique case (psc_e'(sel))
            PSC_DIV_A: lim = '0;
            PSC_DIV_B: lim = PSC_CW'(DIV_B - 1);
            PSC_DIV_C: lim = PSC_CW'(DIV_C - 1);
            default:   lim = PSC_CW'(DIV_D - 1);
         endcase
      end

      assign tick = run && (cnt_q == lim);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      cnt_q <= '0;
         else if (!run)   cnt_q <= '0;
         else if (tick)   cnt_q <= '0;
         else             cnt_q <= cnt_q + 1'b1;
      end
   end else begin : g_nodiv
      assign tick = run;
   end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             start,
   input  logic             tick,
   input  logic [CNT_W-1:0] per_stg,
   input  logic [CNT_W-1:0] duty_stg,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] per_act,
   output logic [CNT_W-1:0] duty_act,
   output logic [CNT_W-1:0] cnt_d,
   output logic [CNT_W-1:0] duty_d,
   output logic             wrap
);
   logic [CNT_W-1:0] per_d;

   assign wrap = tick && (cnt_q == per_act);

   always_comb begin
      cnt_d  = cnt_q;
      per_d  = per_act;
      duty_d = duty_act;
      if (!en) begin
         cnt_d = '0;
      end else if (start || wrap) begin
         cnt_d  = '0;
         per_d  = per_stg;
         duty_d = duty_stg;
      end else if (tick) begin
         cnt_d = cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         per_act  <= '0;
         duty_act <= '0;
      end else begin
         cnt_q    <= cnt_d;
         per_act  <= per_d;
         duty_act <= duty_d;
      end
   end
endmodule

// File: rtl/pwm_compare.sv
module pwm_compare #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [CNT_W-1:0] cnt_d,
   input  logic [CNT_W-1:0] duty_d,
   output logic             out_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_q <= 1'b0;
      else        out_q <= en && (cnt_d < duty_d);
   end
endmodule

// File: rtl/pwm_dbuf.sv
module pwm_dbuf #(
   parameter int CNT_W   = 16,
   parameter int DIV_B   = 8,
   parameter int DIV_C   = 64,
   parameter int DIV_D   = 256,
   parameter bit HAS_PSC = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [1:0]       psc_sel,
   input  logic             wr_en,
   input  logic             wr_sel,
   input  logic [CNT_W-1:0] wr_data,
   output logic             pwm_out
);
   if (CNT_W < 2) begin : g_bad_width
      $error("pwm_dbuf: CNT_W must be at least 2");
   end

   logic             en_q;
   logic             start;
   logic             tick;
   logic             wrap;
   logic [CNT_W-1:0] per_stg, duty_stg;
   logic [CNT_W-1:0] cnt_q, per_act, duty_act, cnt_d, duty_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= 1'b0;
      else        en_q <= en;
   end

   assign start = en && !en_q;

   pwm_regs #(.CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .per_stg(per_stg), .duty_stg(duty_stg)
   );

   pwm_prescaler #(.DIV_B(DIV_B), .DIV_C(DIV_C), .DIV_D(DIV_D), .HAS_PSC(HAS_PSC)) u_psc (
      .clk(clk), .rst_n(rst_n), .run(en && en_q), .sel(psc_sel), .tick(tick)
   );

   pwm_timebase #(.CNT_W(CNT_W)) u_tb (
      .clk(clk), .rst_n(rst_n), .en(en), .start(start), .tick(tick),
      .per_stg(per_stg), .duty_stg(duty_stg), .cnt_q(cnt_q),
      .per_act(per_act), .duty_act(duty_act), .cnt_d(cnt_d),
      .duty_d(duty_d), .wrap(wrap)
   );

   pwm_compare #(.CNT_W(CNT_W)) u_cmp (
      .clk(clk), .rst_n(rst_n), .en(en), .cnt_d(cnt_d),
      .duty_d(duty_d), .out_q(pwm_out)
   );
endmodule

// File: rtl/pwm_dbuf_chk.sv
module pwm_dbuf_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en,
   input logic             pwm_out,
   input logic             run,
   input logic             wrap,
   input logic [CNT_W-1:0] cnt_q,
   input logic [CNT_W-1:0] per_act,
   input logic [CNT_W-1:0] duty_act
);
   a_r8_off_low: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !pwm_out);

   a_r6_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
      (duty_act == '0) |-> !pwm_out);

   a_r7_full_high: assert property (@(posedge clk) disable iff (!rst_n)
      (run && (duty_act > per_act)) |-> pwm_out);

   a_r1_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt_q <= per_act));

   a_r4_duty_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run) && !$past(wrap)) |-> $stable(duty_act));

   a_r5_per_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run) && !$past(wrap)) |-> $stable(per_act));
endmodule

bind pwm_dbuf pwm_dbuf_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .en(en), .pwm_out(pwm_out), .run(en_q),
   .wrap(wrap), .cnt_q(cnt_q), .per_act(per_act), .duty_act(duty_act)
);

// File: tb/sim_pwm_dbuf.sv
module sim_pwm_dbuf;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0;
   logic [1:0]  psc_sel = 2'd0;
   logic        wr_en = 1'b0;
   logic        wr_sel = 1'b0;
   logic [15:0] wr_data = '0;
   logic        pwm_out;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   typedef struct {
      int    high;
      int    len;
      string tag;
   } exp_t;

   exp_t q[$];

   always #10 clk = ~clk;

   pwm_dbuf u0 (
      .clk(clk), .rst_n(rst_n), .en(en), .psc_sel(psc_sel), .wr_en(wr_en),
      .wr_sel(wr_sel), .wr_data(wr_data), .pwm_out(pwm_out)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles == 150000) begin
         errors = errors + 1;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int expv);
      checks = checks + 1;
      if (!ok) begin
         errors = errors + 1;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   // Monitor: one queued item covers one full period beginning at the next negedge.
   initial begin
      forever begin
         @(negedge clk);
         if (q.size() > 0) begin
            exp_t it;
            int   hi;
            int   rises;
            bit   first;
            bit   prev;
            it = q.pop_front();
            first = pwm_out;
            prev = pwm_out;
            hi = pwm_out ? 1 : 0;
            rises = 0;
            for (int i = 1; i < it.len; i++) begin
               @(negedge clk);
               if (pwm_out) hi = hi + 1;
               if (pwm_out && !prev) rises = rises + 1;
               prev = pwm_out;
            end
            check(hi == it.high, {it.tag, " high cycles"}, hi, it.high);
            check(rises == 0 && first == (it.high > 0), {it.tag, " pulse shape"},
                  int'(first), int'(it.high > 0));
         end
      end
   end

   task automatic wr(input bit sel, input int val);
      wr_en = 1'b1;
      wr_sel = sel;
      wr_data = 16'(val);
      @(posedge clk);
      #1;
      wr_en = 1'b0;
   endtask

   task automatic start_run(input int psc, input int per, input int duty);
      psc_sel = 2'(psc);
      wr(1'b0, per);
      wr(1'b1, duty);
      en = 1'b1;
      @(posedge clk);
      #1;
   endtask

   task automatic expect_period(input int high, input int len, input string tag);
      exp_t it;
      it.high = high;
      it.len = len;
      it.tag = tag;
      q.push_back(it);
      repeat (len) @(posedge clk);
      #1;
   endtask

   task automatic stop_run(input string tag);
      en = 1'b0;
      @(posedge clk);
      #1;
      check(pwm_out == 1'b0, tag, int'(pwm_out), 0);
      repeat (2) @(posedge clk);
      #1;
   endtask

   initial begin
      exp_t it;
      repeat (3) @(posedge clk);
      #1;
      check(pwm_out == 1'b0, "R9 reset output", int'(pwm_out), 0);
      rst_n = 1'b1;
      @(posedge clk);
      #1;

      // R9 / R6: enable without writes, so period and duty are both zero.
      en = 1'b1;
      @(posedge clk);
      #1;
      expect_period(0, 1, "R9 all-zero period");
      expect_period(0, 1, "R6 all-zero period");
      stop_run("R8 off after zero run");

      // R1 / R3 / R10: period 7, duty 3, divide 1. A swapped decode would give period 3, duty 7.
      start_run(0, 7, 3);
      expect_period(3, 8, "R1 R10 period 8");
      expect_period(3, 8, "R3 second period");
      stop_run("R8 off");

      // R2: each divide ratio.
      start_run(1, 3, 2);
      expect_period(16, 32, "R2 div8");
      stop_run("R8 off div8");
      start_run(2, 2, 1);
      expect_period(64, 192, "R2 div64");
      stop_run("R8 off div64");
      start_run(3, 1, 1);
      expect_period(256, 512, "R2 div256");
      stop_run("R8 off div256");

      // R6 zero duty, R7 above-period duty, R3 duty equal to the period value.
      start_run(0, 5, 0);
      expect_period(0, 6, "R6 duty zero");
      stop_run("R8 off r6");
      start_run(0, 5, 6);
      expect_period(6, 6, "R7 duty period+1");
      stop_run("R8 off r7a");
      start_run(0, 5, 9);
      expect_period(6, 6, "R7 duty above period");
      stop_run("R8 off r7b");
      start_run(0, 5, 5);
      expect_period(5, 6, "R3 duty equals period");
      stop_run("R8 off r3");

      // R4: duty written mid-period.
      start_run(0, 7, 2);
      it.high = 2; it.len = 8; it.tag = "R4 current period kept";
      q.push_back(it);
      repeat (3) @(posedge clk);
      #1;
      wr(1'b1, 6);
      repeat (4) @(posedge clk);
      #1;
      expect_period(6, 8, "R4 next period new duty");
      stop_run("R8 off r4");

      // R5: period written mid-period.
      start_run(0, 7, 2);
      it.high = 2; it.len = 8; it.tag = "R5 current length kept";
      q.push_back(it);
      repeat (3) @(posedge clk);
      #1;
      wr(1'b0, 3);
      repeat (4) @(posedge clk);
      #1;
      expect_period(2, 4, "R5 next period new length");
      expect_period(2, 4, "R5 following period");

      // R8: disable mid-period, then re-enable and expect a full fresh period.
      repeat (2) @(posedge clk);
      #1;
      stop_run("R8 output low after disable");
      en = 1'b1;
      @(posedge clk);
      #1;
      expect_period(2, 4, "R8 restart full period");
      stop_run("R8 off final");

      repeat (4) @(posedge clk);
      check(q.size() == 0, "monitor drained", q.size(), 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule